// File: doc/BRIEF.md
# Tachometer Speed and Phase Discriminator

This block compares a motor tachometer pulse train against a crystal time base. A prescaler divides the system clock into reference ticks. A period meter counts the ticks between consecutive rising edges of the tachometer input. The nominal period is 512 ticks, so the target tachometer frequency is the clock frequency divided by 8192 when the prescaler divides by 16.

Each finished period drives three results. A phase pump pair answers on every period. A speed pump pair answers on every second period. An active-low lock flag reports whether the period lies within ±6.25 % of nominal. Each pump output is a pulse whose width in reference ticks grows with the count error. An external charge pump and integrator would turn these pulses into a drive level; that analog part is outside the block.

The block is held idle while the run enable is low. After enable, the first tachometer edge only starts the measurement; results begin with the second edge.

Top module: `fgd_speed_disc`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it falls, all four pump outputs are low and `lock_n_o` is high.
- R2: The period count advances by one on each reference tick, which occurs once every DIV clocks. A count that reaches 1023 holds there, so a stalled motor reads as the longest period.
- R3: The tachometer input passes through a two-flop synchronizer, and only its rising edges count. The first rising edge after reset or enable starts the count and produces no result; `lock_n_o` stays high until a full period has been measured.
- R4: `lock_n_o` changes only when a period ends, or when reset or disable clears it. It goes low exactly when the measured count m satisfies 480 ≤ m ≤ 544, and high otherwise.
- R5: On every measured period the phase pair responds. `pll_dn_o` is a pulse of min(512−m, 255) ticks when m < 512. `pll_up_o` is a pulse of min(m−512, 255) ticks when m > 512. A new result replaces any pulse still running on that pair.
- R6: Only on the 2nd, 4th, 6th and later even-numbered measurements after enable does the speed pair respond. `over_o` (period too short) then pulses for min(512−m, 255) ticks and `under_o` for min(m−512, 255) ticks. On odd-numbered measurements the speed pair gets no new result. Each pair never drives both of its outputs at once.
- R7: A measured count of exactly 512 leaves both outputs of each responding pair low.
- R8: While `run_en` is low, the period count, the result parity and all pulses are cleared, and `lock_n_o` is high.
- R9: Pump pulse widths saturate at 255 ticks, so a stalled-motor reading gives a 255-tick pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Run enable; low stops and clears the measurement |
| fg_in | input | 1 | Squared tachometer pulse, asynchronous |
| over_o | output | 1 | Speed pump: period shorter than nominal |
| under_o | output | 1 | Speed pump: period longer than nominal |
| pll_up_o | output | 1 | Phase pump up (motor slow) |
| pll_dn_o | output | 1 | Phase pump down (motor fast) |
| lock_n_o | output | 1 | Low while the last measured period is in the lock window |

## Verification
On every cycle the assertions check several properties. Neither pump pair drives both outputs at once. The reference tick is a single-cycle pulse. `lock_n_o` moves only at a period end or a clear. A pump pulse starts only from a measurement, and the speed pair only on an even-numbered one. Disable and reset leave every output cleared. Only the bench scenarios can show the remaining behaviour: the actual pulse widths against the count error, the exact window edges at 479/480 and 544/545, saturation after a stall, and the silent first edge after enable.

// File: rtl/fgd_pkg.sv
package fgd_pkg;
    typedef enum logic [1:0] {
        SPD_EXACT = 2'd0,
        SPD_FAST  = 2'd1,
        SPD_SLOW  = 2'd2
    } spd_dir_e;
endpackage

// File: rtl/fgd_prescale.sv
module fgd_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr)               pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) pre_q <= pre_d;

    assign tick = (pre_q == LAST);
endmodule

// File: rtl/fgd_edge_sync.sv
module fgd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        if (rst) sh_d = '0;
        else     sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) sh_q <= sh_d;

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/fgd_pump.sv
module fgd_pump #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          tick,
    input  logic          load,
    input  logic [PW-1:0] up_w,
    input  logic [PW-1:0] dn_w,
    output logic          up_o,
    output logic          dn_o
);
    typedef struct packed {
        logic [PW-1:0] up;
        logic [PW-1:0] dn;
    } rem_t;

    rem_t rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (clr) begin
            rem_d = '0;
        end else if (load) begin
            rem_d.up = up_w;
            rem_d.dn = dn_w;
        end else if (tick) begin
            if (rem_q.up != '0) rem_d.up = rem_q.up - 1'b1;
            if (rem_q.dn != '0) rem_d.dn = rem_q.dn - 1'b1;
        end
    end

    always_ff @(posedge clk) rem_q <= rem_d;

    assign up_o = (rem_q.up != '0);
    assign dn_o = (rem_q.dn != '0);
endmodule

// File: rtl/fgd_speed_disc.sv
module fgd_speed_disc #(
    parameter int DIV    = 16,
    parameter int NOM    = 512,
    parameter int WIN    = 32,
    parameter int CNT_W  = 10,
    parameter int PW     = 8,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic fg_in,
    output logic over_o,
    output logic under_o,
    output logic pll_up_o,
    output logic pll_dn_o,
    output logic lock_n_o
);
    import fgd_pkg::*;

    localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] NOM_V  = CNT_W'(NOM);
    localparam logic [CNT_W-1:0] LO_V   = CNT_W'(NOM - WIN);
    localparam logic [CNT_W-1:0] HI_V   = CNT_W'(NOM + WIN);
    localparam logic [CNT_W-1:0] PMAX_V = CNT_W'((1 << PW) - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             started;
        logic             odd;
        logic             lock_n;
    } meter_t;

    meter_t        st_d, st_q;
    logic          clr, tick, rise, meas_done, disc_load;
    spd_dir_e      dir;
    logic [CNT_W-1:0] gap;
    logic [PW-1:0] width, up_w, dn_w;

    assign clr = rst | ~run_en;

    fgd_prescale #(.DIV(DIV)) u_pre (
        .clk (clk),
        .clr (clr),
        .tick(tick)
    );

    fgd_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (fg_in),
        .rise(rise)
    );

    always_comb begin
        if (st_q.cnt < NOM_V)      dir = SPD_FAST;
        else if (st_q.cnt > NOM_V) dir = SPD_SLOW;
        else                       dir = SPD_EXACT;

        gap   = (dir == SPD_FAST) ? (NOM_V - st_q.cnt) : (st_q.cnt - NOM_V);
        width = (gap > PMAX_V) ? PMAX_V[PW-1:0] : gap[PW-1:0];
        up_w  = (dir == SPD_SLOW) ? width : '0;
        dn_w  = (dir == SPD_FAST) ? width : '0;

        meas_done = rise & st_q.started & ~clr;
        disc_load = meas_done & st_q.odd;

        st_d = st_q;
        if (clr) begin
            st_d.cnt     = '0;
            st_d.started = 1'b0;
            st_d.odd     = 1'b0;
            st_d.lock_n  = 1'b1;
        end else if (rise) begin
            st_d.started = 1'b1;
            st_d.cnt     = tick ? CNT_W'(1) : '0;
            if (st_q.started) begin
                st_d.lock_n = ~((st_q.cnt >= LO_V) && (st_q.cnt <= HI_V));
                st_d.odd    = ~st_q.odd;
            end
        end else if (tick && (st_q.cnt != MAX_V)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    fgd_pump #(.PW(PW)) u_phase (
        .clk (clk),
        .clr (clr),
        .tick(tick),
        .load(meas_done),
        .up_w(up_w),
        .dn_w(dn_w),
        .up_o(pll_up_o),
        .dn_o(pll_dn_o)
    );

    fgd_pump #(.PW(PW)) u_disc (
        .clk (clk),
        .clr (clr),
        .tick(tick),
        .load(disc_load),
        .up_w(up_w),
        .dn_w(dn_w),
        .up_o(under_o),
        .dn_o(over_o)
    );

    assign lock_n_o = st_q.lock_n;
endmodule

// File: rtl/fgd_speed_disc_chk.sv
module fgd_speed_disc_chk (
    input logic clk,
    input logic rst,
    input logic run_en,
    input logic tick,
    input logic meas_done,
    input logic disc_load,
    input logic over_o,
    input logic under_o,
    input logic pll_up_o,
    input logic pll_dn_o,
    input logic lock_n_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lock_n_o && !over_o && !under_o && !pll_up_o && !pll_dn_o));

    // R8
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (lock_n_o && !over_o && !under_o && !pll_up_o && !pll_dn_o));

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && run_en) |=> !tick);

    // R4
    lock_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_n_o) |-> $past(rst || !run_en || meas_done));

    // R5
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pll_up_o && pll_dn_o));

    // R6
    speed_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(over_o && under_o));

    // R5
    phase_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pll_up_o) || $rose(pll_dn_o)) |-> $past(meas_done));

    // R6
    speed_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(over_o) || $rose(under_o)) |-> $past(disc_load));
endmodule

bind fgd_speed_disc fgd_speed_disc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .tick     (tick),
    .meas_done(meas_done),
    .disc_load(disc_load),
    .over_o   (over_o),
    .under_o  (under_o),
    .pll_up_o (pll_up_o),
    .pll_dn_o (pll_dn_o),
    .lock_n_o (lock_n_o)
);

// File: tb/fgd_speed_disc_tb.sv
module fgd_speed_disc_tb;
    localparam int DIV = 4;
    localparam int NOM = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic fg_in = 1'b0;
    logic over_o, under_o, pll_up_o, pll_dn_o, lock_n_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fgd_speed_disc #(.DIV(DIV)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .fg_in   (fg_in),
        .over_o  (over_o),
        .under_o (under_o),
        .pll_up_o(pll_up_o),
        .pll_dn_o(pll_dn_o),
        .lock_n_o(lock_n_o)
    );

    // behavioural reference model
    int m_pre, m_cnt, r_over, r_under, r_up, r_dn;
    bit m_s1, m_s2, m_s3, m_started, m_odd, m_lock_n, m_valid;
    int mw, tk_i, rs_i;

    initial m_valid = 1'b0;

    always @(posedge clk) begin
        tk_i = (m_pre == DIV - 1) ? 1 : 0;
        rs_i = (m_s2 && !m_s3) ? 1 : 0;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_valid = 1'b1;
        end else begin
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = fg_in;
        end
        if (rst || !run_en) begin
            m_pre = 0; m_cnt = 0; m_started = 0; m_odd = 0; m_lock_n = 1;
            r_over = 0; r_under = 0; r_up = 0; r_dn = 0;
        end else begin
            m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
            if (tk_i != 0) begin
                if (r_over > 0) r_over--;
                if (r_under > 0) r_under--;
                if (r_up > 0) r_up--;
                if (r_dn > 0) r_dn--;
            end
            if (rs_i != 0) begin
                if (m_started) begin
                    mw = (m_cnt > NOM) ? m_cnt - NOM : NOM - m_cnt;
                    if (mw > 255) mw = 255;
                    r_up = (m_cnt > NOM) ? mw : 0;
                    r_dn = (m_cnt < NOM) ? mw : 0;
                    if (m_odd) begin
                        r_under = r_up;
                        r_over  = r_dn;
                    end
                    m_lock_n = !(m_cnt >= 480 && m_cnt <= 544);
                    m_odd = !m_odd;
                end
                m_started = 1;
                m_cnt = tk_i;
            end else if (tk_i != 0 && m_cnt < 1023) begin
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (m_valid && !finished) begin
            total++;
            if (over_o !== (r_over > 0) || under_o !== (r_under > 0)) begin
                bad++;
                $display("FAIL R6 cycle model: over/under act=%b%b exp=%b%b",
                         over_o, under_o, r_over > 0, r_under > 0);
            end
            if (pll_up_o !== (r_up > 0) || pll_dn_o !== (r_dn > 0)) begin
                bad++;
                $display("FAIL R5 cycle model: up/dn act=%b%b exp=%b%b",
                         pll_up_o, pll_dn_o, r_up > 0, r_dn > 0);
            end
            if (lock_n_o !== m_lock_n) begin
                bad++;
                $display("FAIL R4 cycle model: lock_n act=%b exp=%b", lock_n_o, m_lock_n);
            end
        end
    end

    // high-cycle counters for scenario checks
    int hi_over, hi_under, hi_up, hi_dn;
    always @(negedge clk) begin
        if (over_o === 1'b1)   hi_over++;
        if (under_o === 1'b1)  hi_under++;
        if (pll_up_o === 1'b1) hi_up++;
        if (pll_dn_o === 1'b1) hi_dn++;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_width(input int act, input int w, input string req, input string what);
        if (w == 0) check(act == 0, req, what, act, 0);
        else check(act >= (w - 1) * DIV + 1 && act <= w * DIV, req, what, act, w * DIV);
    endtask

    task automatic fg_period(input int p);
        fg_in = 1'b1;
        repeat (8) @(negedge clk);
        fg_in = 1'b0;
        repeat (p * DIV - 8) @(negedge clk);
    endtask

    // one tachometer period of p ticks; its leading edge ends the previous period (m)
    task automatic seg(input int p, input int m, input bit has_meas, input bit even, input string req);
        int w;
        hi_over = 0; hi_under = 0; hi_up = 0; hi_dn = 0;
        fg_period(p);
        if (!has_meas) begin
            check(hi_over + hi_under + hi_up + hi_dn == 0, req, "no pulse on start edge",
                  hi_over + hi_under + hi_up + hi_dn, 0);
            check(lock_n_o === 1'b1, req, "lock_n after start edge", lock_n_o, 1);
        end else begin
            w = (m > NOM) ? m - NOM : NOM - m;
            if (w > 255) w = 255;
            check_width(hi_up, (m > NOM) ? w : 0, req, "pll_up width");
            check_width(hi_dn, (m < NOM) ? w : 0, req, "pll_dn width");
            check_width(hi_under, (even && m > NOM) ? w : 0, "R6", "under width");
            check_width(hi_over, (even && m < NOM) ? w : 0, "R6", "over width");
            check(lock_n_o === !(m >= 480 && m <= 544), "R4", "lock_n level",
                  lock_n_o, !(m >= 480 && m <= 544));
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs during reset
        check(lock_n_o === 1'b1 && {over_o, under_o, pll_up_o, pll_dn_o} === 4'b0,
              "R1", "outputs in reset", {lock_n_o, over_o, under_o, pll_up_o, pll_dn_o}, 5'b10000);
        rst = 1'b0;
        run_en = 1'b1;
        @(negedge clk);
        check(lock_n_o === 1'b1 && {over_o, under_o, pll_up_o, pll_dn_o} === 4'b0,
              "R1", "outputs after reset", {lock_n_o, over_o, under_o, pll_up_o, pll_dn_o}, 5'b10000);

        seg(512, 0,   0, 0, "R3");
        seg(512, 512, 1, 0, "R7");
        seg(512, 512, 1, 1, "R7");
        seg(500, 512, 1, 0, "R7");
        seg(500, 500, 1, 1, "R5");
        seg(560, 500, 1, 0, "R5");
        seg(560, 560, 1, 1, "R5");
        seg(544, 560, 1, 0, "R5");
        seg(480, 544, 1, 1, "R5");
        seg(479, 480, 1, 0, "R5");
        seg(512, 479, 1, 1, "R5");
        // stall: long gap saturates the period count (R2), pulse clamps (R9)
        repeat (1100 * DIV) @(negedge clk);
        seg(512, 1023, 1, 0, "R9 R2");
        seg(512, 512, 1, 1, "R7");

        // R8: disable mid-period clears everything
        fg_in = 1'b1;
        repeat (8) @(negedge clk);
        fg_in = 1'b0;
        repeat (100) @(negedge clk);
        run_en = 1'b0;
        repeat (10) @(negedge clk);
        check(lock_n_o === 1'b1 && {over_o, under_o, pll_up_o, pll_dn_o} === 4'b0,
              "R8", "outputs while disabled", {lock_n_o, over_o, under_o, pll_up_o, pll_dn_o}, 5'b10000);
        run_en = 1'b1;
        repeat (10) @(negedge clk);
        seg(512, 0,   0, 0, "R3");
        seg(512, 512, 1, 0, "R4");
        seg(520, 512, 1, 1, "R4");
        repeat (20) @(negedge clk);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule